// File: doc/BRIEF.md
# Infrared Dongle Indexed-Register Serial Master

This block lets on-chip logic read and write the small indexed register file inside an external infrared transceiver dongle. The link has two wires: a clock driven by the master and a data line split into a transmit output and a receive input. A caller presents a register address, an index, a direction flag and, for writes, a data byte, and then pulses `start`. The block forms a command byte and sends it bit by bit. It then either sends the data byte or searches for the dongle's acknowledge and shifts in the reply. Each transaction finishes with a fixed tail of clock pulses, after which `done` pulses for one cycle.

All link activity is built from one unit, the pulse slot. In a slot the clock is low for 2H system cycles and then high for H cycles, where H is the programmable `half_len`. TX is set once, at the start of each slot. A separate request runs a dongle reset made of a long train of slots with TX low. While a sequence is running, new requests are not accepted.

Top module: `dngl_idx_master`

## Requirements
- R1: The command byte is `reg_addr | (reg_idx << 1) | dir`, where `dir` (bit 0) is 1 for a write and 0 for a read.
- R2: Every byte sent starts with one marker slot with TX high, followed by 8 slots carrying the byte least significant bit first.
- R3: TX changes only while the clock is low. It never changes during a high phase or at a rising clock edge.
- R4: The low phase of each slot lasts 2H cycles and the high phase lasts H cycles. A `half_len` of 0 is treated as 1. A sequence of N slots keeps `busy` high for exactly 3·H·N cycles.
- R5: Every register transaction starts with one slot with TX low, before the command byte.
- R6: A write sends the command byte, then the data byte, then 2 slots with TX low, for 21 slots in total.
- R7: A read's acknowledge search uses up to 10 slots. TX is low in the first slot and high in the rest. RX is sampled in the last cycle of each high phase, and a low sample ends the search as the acknowledge.
- R8: After an acknowledge, 8 slots with TX high follow. In the last low-phase cycle of slot i (i = 0 to 7), RX becomes bit i of `rd_data`, and `ack_timeout` is 0.
- R9: If none of the 10 search slots sees RX low, 2 slots with TX high follow, `rd_data` is 0 and `ack_timeout` is 1.
- R10: Every read ends with 1 slot with TX high and then 3 slots with TX low. A read acknowledged in search slot L therefore uses 22+L slots, and an unacknowledged read uses 26.
- R11: `dngl_rst_req` runs 30 slots with TX low. If it arrives in the same cycle as `start`, the reset sequence wins.
- R12: `done` pulses for one cycle in the first cycle with `busy` low after a sequence. The clock and TX are low whenever the block is idle. `start` and `dngl_rst_req` are ignored while `busy` is high.
- R13: Right after reset, `sclk`, `txd`, `busy`, `done`, `rd_data` and `ack_timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a register transaction when idle |
| dngl_rst_req | input | 1 | Starts the dongle reset sequence when idle |
| wr_en | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 8 | Address part of the command byte |
| reg_idx | input | 7 | Register index, shifted left by one into the command byte |
| wr_data | input | 8 | Data byte for writes |
| half_len | input | DIV_W | High-phase length H in cycles (low phase is 2H) |
| rxd | input | 1 | Receive line from the dongle |
| sclk | output | 1 | Link clock to the dongle |
| txd | output | 1 | Transmit line to the dongle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| rd_data | output | 8 | Byte captured by the last read |
| ack_timeout | output | 1 | The last read saw no acknowledge |

## Verification
A wrong slot counter or state shows up as a TX value that differs from the expected one at the very next rising clock edge. It also changes the total slot count, and the slot count fixes the length of `busy` and the cycle in which `done` appears. A wrong phase timer changes the length of `busy` by a multiple of H, which is seen when the sequence ends. A mis-sampled acknowledge or data bit changes the number of slots in the read, `rd_data` or `ack_timeout`, and all three are checked when `done` pulses.

// File: rtl/dngl_pkg.sv
package dngl_pkg;
  localparam int BYTE_SLOTS  = 9;   // marker + 8 data bits
  localparam int WTAIL_SLOTS = 2;
  localparam int ACK_SLOTS   = 10;
  localparam int RDAT_SLOTS  = 8;
  localparam int DUMMY_SLOTS = 2;
  localparam int RTAIL_SLOTS = 4;   // 1 high + 3 low
  localparam int RST_SLOTS   = 30;
  localparam int CNT_W       = $clog2(RST_SLOTS);

  typedef logic [CNT_W-1:0] slot_cnt_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPEN, ST_CMD, ST_WDAT, ST_WTAIL,
    ST_ACK, ST_RDAT, ST_DUMMY, ST_RTAIL, ST_RST
  } seq_st_t;
endpackage

// File: rtl/dngl_cmd_pack.sv
module dngl_cmd_pack (
  input  logic [7:0] addr,
  input  logic [6:0] idx,
  input  logic       wr,
  output logic [7:0] cmd
);
  assign cmd = addr | {idx, 1'b0} | {7'b0, wr};
endmodule

// File: rtl/dngl_phase_timer.sv
module dngl_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hi,
  input  logic [DIV_W-1:0] half_len,
  output logic             last
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W:0]   span, cnt_q, cnt_d;

  always_comb begin
    eff  = (half_len == '0) ? DIV_W'(1) : half_len;
    span = hi ? {1'b0, eff} : {eff, 1'b0};
    last = run && (cnt_q >= span - 1'b1);
    cnt_d = (!run || last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/dngl_seq.sv
module dngl_seq
  import dngl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       rst_req,
  input  logic       wr_in,
  input  logic [7:0] cmd_in,
  input  logic [7:0] wdat_in,
  input  logic       rxd,
  input  logic       last,
  output logic       sclk,
  output logic       txd,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ack_to
);
  localparam slot_cnt_t BYTE_LAST  = slot_cnt_t'(BYTE_SLOTS - 1);
  localparam slot_cnt_t WTAIL_LAST = slot_cnt_t'(WTAIL_SLOTS - 1);
  localparam slot_cnt_t ACK_LAST   = slot_cnt_t'(ACK_SLOTS - 1);
  localparam slot_cnt_t RDAT_LAST  = slot_cnt_t'(RDAT_SLOTS - 1);
  localparam slot_cnt_t DUMMY_LAST = slot_cnt_t'(DUMMY_SLOTS - 1);
  localparam slot_cnt_t RTAIL_LAST = slot_cnt_t'(RTAIL_SLOTS - 1);
  localparam slot_cnt_t RST_LAST   = slot_cnt_t'(RST_SLOTS - 1);

  seq_st_t   st_q, st_d;
  slot_cnt_t cnt_q, cnt_d;
  logic      ph_q, ph_d;
  logic      wr_q, wr_d;
  logic [7:0] cmd_q, cmd_d, wdat_q, wdat_d, rdat_q, rdat_d;
  logic      to_q, to_d, done_q, done_d;
  logic [2:0] bsel;

  // next-state
  always_comb begin
    st_d = st_q; cnt_d = cnt_q; ph_d = ph_q; wr_d = wr_q;
    cmd_d = cmd_q; wdat_d = wdat_q; rdat_d = rdat_q; to_d = to_q;
    done_d = 1'b0;
    if (st_q == ST_IDLE) begin
      ph_d  = 1'b0;
      cnt_d = '0;
      if (rst_req) begin
        st_d = ST_RST;
      end else if (go) begin
        st_d   = ST_OPEN;
        wr_d   = wr_in;
        cmd_d  = cmd_in;
        wdat_d = wdat_in;
        to_d   = 1'b0;
        if (!wr_in) rdat_d = '0;
      end
    end else begin
      if (last) ph_d = ~ph_q;
      if (last && !ph_q && st_q == ST_RDAT) rdat_d[cnt_q[2:0]] = rxd;
      if (last && ph_q) begin
        cnt_d = cnt_q + 1'b1;
        case (st_q)
          ST_OPEN: begin st_d = ST_CMD; cnt_d = '0; end
          ST_CMD: if (cnt_q == BYTE_LAST) begin
            st_d = wr_q ? ST_WDAT : ST_ACK; cnt_d = '0;
          end
          ST_WDAT: if (cnt_q == BYTE_LAST) begin
            st_d = ST_WTAIL; cnt_d = '0;
          end
          ST_WTAIL: if (cnt_q == WTAIL_LAST) begin
            st_d = ST_IDLE; done_d = 1'b1;
          end
          ST_ACK: begin
            if (!rxd) begin
              st_d = ST_RDAT; cnt_d = '0;
            end else if (cnt_q == ACK_LAST) begin
              st_d = ST_DUMMY; cnt_d = '0; to_d = 1'b1;
            end
          end
          ST_RDAT: if (cnt_q == RDAT_LAST) begin
            st_d = ST_RTAIL; cnt_d = '0;
          end
          ST_DUMMY: if (cnt_q == DUMMY_LAST) begin
            st_d = ST_RTAIL; cnt_d = '0;
          end
          ST_RTAIL: if (cnt_q == RTAIL_LAST) begin
            st_d = ST_IDLE; done_d = 1'b1;
          end
          ST_RST: if (cnt_q == RST_LAST) begin
            st_d = ST_IDLE; done_d = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; ph_q <= 1'b0; wr_q <= 1'b0;
      cmd_q <= '0; wdat_q <= '0; rdat_q <= '0; to_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; ph_q <= ph_d; wr_q <= wr_d;
      cmd_q <= cmd_d; wdat_q <= wdat_d; rdat_q <= rdat_d; to_q <= to_d;
      done_q <= done_d;
    end
  end

  // TX value held for the whole slot
  always_comb begin
    bsel = cnt_q[2:0] - 3'd1;
    case (st_q)
      ST_CMD:   txd = (cnt_q == '0) ? 1'b1 : cmd_q[bsel];
      ST_WDAT:  txd = (cnt_q == '0) ? 1'b1 : wdat_q[bsel];
      ST_ACK:   txd = (cnt_q != '0);
      ST_RDAT:  txd = 1'b1;
      ST_DUMMY: txd = 1'b1;
      ST_RTAIL: txd = (cnt_q == '0);
      default:  txd = 1'b0;
    endcase
  end

  assign sclk   = ph_q;
  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign rdata  = rdat_q;
  assign ack_to = to_q;

  // R3
  tx_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> !sclk);
  // R3
  tx_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(txd));
  // R12
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !txd));
  // R9
  timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_to && !busy) |-> (rdata == 8'h00));
endmodule

// File: rtl/dngl_idx_master.sv
module dngl_idx_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dngl_rst_req,
  input  logic             wr_en,
  input  logic [7:0]       reg_addr,
  input  logic [6:0]       reg_idx,
  input  logic [7:0]       wr_data,
  input  logic [DIV_W-1:0] half_len,
  input  logic             rxd,
  output logic             sclk,
  output logic             txd,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             ack_timeout
);
  logic [7:0] cmd_byte;
  logic       ph_last;

  dngl_cmd_pack u_pack (
    .addr (reg_addr),
    .idx  (reg_idx),
    .wr   (wr_en),
    .cmd  (cmd_byte)
  );

  dngl_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .hi       (sclk),
    .half_len (half_len),
    .last     (ph_last)
  );

  dngl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (start),
    .rst_req (dngl_rst_req),
    .wr_in   (wr_en),
    .cmd_in  (cmd_byte),
    .wdat_in (wr_data),
    .rxd     (rxd),
    .last    (ph_last),
    .sclk    (sclk),
    .txd     (txd),
    .busy    (busy),
    .done    (done),
    .rdata   (rd_data),
    .ack_to  (ack_timeout)
  );
endmodule

// File: tb/sim_dngl_idx_master.sv
`timescale 1ns/1ps
module sim_dngl_idx_master;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rst_req = 1'b0, wr_en = 1'b0;
  logic [7:0] reg_addr = '0, wr_data = '0;
  logic [6:0] reg_idx = '0;
  logic [DIV_W-1:0] half_len = 1;
  logic rxd, sclk, txd, busy, done, ack_timeout;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  int rise_n = 0, base = 0, ack_lat = 0, rel, tx_bad = 0;
  logic [7:0] resp_data = '0;
  logic rec [64];
  logic [63:0] ex;
  int ex_n;
  logic prev_tx = 1'b0;

  always #2 clk = ~clk;

  dngl_idx_master #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dngl_rst_req(rst_req),
    .wr_en(wr_en), .reg_addr(reg_addr), .reg_idx(reg_idx), .wr_data(wr_data),
    .half_len(half_len), .rxd(rxd), .sclk(sclk), .txd(txd), .busy(busy),
    .done(done), .rd_data(rd_data), .ack_timeout(ack_timeout)
  );

  // dongle responder: records TX at each rise, answers on RX
  always @(posedge sclk) begin
    rec[rise_n % 64] <= txd;
    rise_n <= rise_n + 1;
  end
  assign rel = rise_n - base;
  assign rxd = (ack_lat == 0) ? 1'b1 :
               (sclk && rel == 10 + ack_lat) ? 1'b0 :
               (!sclk && rel >= 10 + ack_lat && rel < 18 + ack_lat) ?
                 resp_data[3'(rel - 10 - ack_lat)] : 1'b1;

  // R3 monitor: TX must not move while the clock is high
  always @(negedge clk) begin
    if (txd !== prev_tx && sclk === 1'b1) tx_bad <= tx_bad + 1;
    prev_tx <= txd;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push(input logic b);
    ex[ex_n] = b;
    ex_n++;
  endtask

  task automatic push_byte(input logic [7:0] b);
    push(1'b1);
    for (int i = 0; i < 8; i++) push(b[i]);
  endtask

  // run one sequence and check the common end-of-sequence behaviour
  task automatic run_seq(input bit rq_rst, input bit w, input logic [7:0] a,
                         input logic [6:0] ix, input logic [7:0] wd, input int lat,
                         input logic [7:0] rsp, input int h, input bit inject,
                         input string tag);
    int cyc, nr, heff;
    logic [63:0] act;
    heff = (h == 0) ? 1 : h;
    @(negedge clk);
    half_len = DIV_W'(h); ack_lat = lat; resp_data = rsp; base = rise_n;
    rst_req = rq_rst; start = 1'b1; wr_en = w;
    reg_addr = a; reg_idx = ix; wr_data = wd;
    @(negedge clk);
    start = 1'b0; rst_req = 1'b0;
    cyc = 0;
    while (busy && cyc < 20000) begin
      cyc++;
      if (inject && cyc == 12) begin
        start = 1'b1; rst_req = 1'b1; wr_en = ~w; reg_addr = 8'hFF;
      end else begin
        start = 1'b0; rst_req = 1'b0;
      end
      @(negedge clk);
    end
    nr = rise_n - base;
    chk(nr == ex_n, {tag, " pulse count"}, nr, ex_n);
    act = '0;
    for (int i = 0; i < ex_n; i++) act[i] = rec[(base + i) % 64];
    chk(act == ex, {tag, " TX bit sequence"}, act, ex);
    // R4
    chk(cyc == 3 * heff * ex_n, "R4 busy length", cyc, 3 * heff * ex_n);
    // R12
    chk(done === 1'b1, "R12 done at end", done, 1);
    chk(sclk === 1'b0 && txd === 1'b0, "R12 idle lines", {sclk, txd}, 0);
    @(negedge clk);
    chk(done === 1'b0, "R12 done width", done, 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13
    chk(sclk === 0 && txd === 0 && busy === 0 && done === 0,
        "R13 reset lines", {sclk, txd, busy, done}, 0);
    chk(rd_data === 8'h00 && ack_timeout === 1'b0, "R13 reset status",
        {ack_timeout, rd_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [6:0] ix,
                         input logic [7:0] wd, input int h, input bit inject);
    ex = '0; ex_n = 0;
    push(1'b0);                                  // R5
    push_byte(a | {ix, 1'b0} | 8'h01);           // R1 R2
    push_byte(wd);
    push(1'b0); push(1'b0);                      // R6
    run_seq(1'b0, 1'b1, a, ix, wd, 0, 8'h00, h, inject, "R6 write");
  endtask

  task automatic t_read(input logic [7:0] a, input logic [6:0] ix, input int lat,
                        input logic [7:0] rsp, input int h);
    ex = '0; ex_n = 0;
    push(1'b0);
    push_byte(a | {ix, 1'b0});                   // R1 read dir = 0
    push(1'b0);                                  // R7 first search slot
    if (lat > 0) begin
      for (int i = 1; i < lat; i++) push(1'b1);
      for (int i = 0; i < 8; i++) push(1'b1);    // R8
    end else begin
      for (int i = 1; i < 10; i++) push(1'b1);
      push(1'b1); push(1'b1);                    // R9 dummies
    end
    push(1'b1); push(1'b0); push(1'b0); push(1'b0); // R10
    run_seq(1'b0, 1'b0, a, ix, 8'h00, lat, rsp, h, 1'b0, "R7 R10 read");
    if (lat > 0) begin
      chk(rd_data === rsp, "R8 read data", rd_data, rsp);
      chk(ack_timeout === 1'b0, "R8 ack flag", ack_timeout, 0);
    end else begin
      chk(rd_data === 8'h00, "R9 data zero", rd_data, 0);
      chk(ack_timeout === 1'b1, "R9 timeout flag", ack_timeout, 1);
    end
  endtask

  task automatic t_dreset(input bit with_start);
    ex = '0; ex_n = 0;
    for (int i = 0; i < 30; i++) push(1'b0);
    run_seq(1'b1, with_start, 8'h12, 7'd5, 8'h77, 0, 8'h00, 1, 1'b0, "R11 dongle reset");
  endtask

  initial begin
    #800000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) rec[i] = 1'b0;
    t_reset_state();
    t_write(8'h40, 7'd2, 8'hA5, 1, 1'b0);
    t_read(8'h40, 7'd1, 1, 8'h3C, 1);    // ack on first search slot
    t_read(8'h40, 7'd3, 10, 8'hC3, 2);   // ack on last search slot
    t_read(8'h40, 7'd0, 0, 8'h5A, 1);    // no acknowledge
    t_read(8'h20, 7'd4, 4, 8'h81, 1);    // R8 flag clears again
    // back-to-back write then read with slower timing
    t_write(8'h40, 7'd7, 8'h0F, 3, 1'b0);
    t_read(8'h40, 7'd7, 3, 8'h96, 3);
    // R4 zero half length acts as one
    t_write(8'h00, 7'd1, 8'hFF, 0, 1'b0);
    t_dreset(1'b0);
    // R11 reset request wins over a simultaneous start
    t_dreset(1'b1);
    // R12 requests while busy are ignored
    t_write(8'h40, 7'd2, 8'h33, 1, 1'b1);
    // R3
    chk(tx_bad == 0, "R3 TX moved while clock high", tx_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule